// File: doc/BRIEF.md
# Data-Strobe Receive Decoder and Clock-Domain Resynchronizer

This block sits behind the line receivers of one cable port of a serial-bus physical layer. It takes two serial streams from the port: the encoded data, which arrives on the A pair, and the encoded strobe, which arrives on the B pair. This is the reverse of the pair assignment used on transmit. The bit clock is not sent on the cable. The block rebuilds it from the pair: every change in the exclusive-OR of data and strobe marks one new bit, and the value of that bit is the data level after the change.

Both streams are oversampled in a fast sample-clock domain. The block decodes each bit there and hands it at once to the repeat path, so that the other connected ports can retransmit it. It also packs the bits into parallel words. At the low speed a word is 2 lines wide; at the high speed it is 4 lines wide. The words then cross through a small Gray-pointer asynchronous FIFO into the local system clock domain, which delivers them to the link layer with a valid flag.

Reception stops whenever the combined receive enable is low. That input is the OR of the power-down, cable-not-active and internal receive-disable conditions, already resolved by the caller. `rx_en_i` and `speed_i` belong to the sample-clock domain.

Top module: `ds_rx_resync`

## Requirements
- R1: While `rx_en_i` is high, each change of (`rx_a_data_i` XOR `rx_b_strb_i`) yields exactly one decoded bit, and its value is the data level after the change. Data is taken from the A-pair input and strobe from the B-pair input.
- R2: Each decoded bit appears on `rep_bit_o` during a single-cycle pulse of `rep_stb_o` in the sample domain, in order of arrival.
- R3: With `speed_i`=0, every 2 bits form one word: the first bit goes to `par_data_o[1]`, the second to `par_data_o[0]`, and `par_data_o[3:2]` is 0.
- R4: With `speed_i`=1, every 4 bits form one word: the first bit goes to `par_data_o[3]` and the last to `par_data_o[0]`.
- R5: Words reach the `clk_i` domain in arrival order, one word per cycle in which `par_valid_o` is high. None is duplicated.
- R6: `par_valid_o` is low in every `clk_i` cycle in which no stored word is available (underflow).
- R7: While `rx_en_i` is low, line changes produce no bit, no repeat pulse and no word, and a partly filled word is discarded. After re-enable, grouping starts from a fresh word.
- R8: A word completed while the FIFO is full is dropped. `ovf_err_o` then goes high and stays high until reset.
- R9: During and after reset, `par_valid_o`, `rep_stb_o` and `ovf_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_s_i | input | 1 | Sample clock for decoding and packing |
| clk_i | input | 1 | Local system clock for the link-side output |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| rx_a_data_i | input | 1 | Encoded data stream from the A pair |
| rx_b_strb_i | input | 1 | Encoded strobe stream from the B pair |
| speed_i | input | 1 | 0: 2-line words, 1: 4-line words |
| rx_en_i | input | 1 | Combined receive enable |
| par_data_o | output | 4 | Parallel word in the `clk_i` domain |
| par_valid_o | output | 1 | `par_data_o` holds a new word |
| rep_bit_o | output | 1 | Decoded bit for the repeat path |
| rep_stb_o | output | 1 | Pulse marking a decoded bit |
| ovf_err_o | output | 1 | Sticky FIFO overflow flag, `clk_i` domain |

## Verification
The bench drives runs of equal bits, where only the strobe toggles, and runs of alternating bits, where only the data toggles. A decoder that watched the data alone would lose the repeated bits, and one with the wrong polarity would invert them.

Bit order within a word is checked in both widths, so a reversed shift direction or a wrong lane count shows up as wrong words. A single bit sent before a disable must vanish. A design that kept the partial word would shift every later word by one bit.

After a stream the FIFO is drained and valid must stay low; a broken empty compare would repeat stale words. A burst faster than the read side must raise the overflow flag, the flag must survive until reset, and fewer words than were sent must come out.

// File: rtl/ds_rx_pkg.sv
package ds_rx_pkg;
  typedef enum logic {SPD_LO = 1'b0, SPD_HI = 1'b1} speed_e;
  localparam int unsigned LANES_LO = 2;
  localparam int unsigned LANES_HI = 4;
endpackage

// File: rtl/ds_sync.sv
module ds_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= {st_q[STAGES-2:0], d_i};
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/ds_edge_decode.sv
module ds_edge_decode #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  input  logic strb_i,
  input  logic en_i,
  output logic bit_o,
  output logic stb_o
);
  logic [1:0] ds_s;
  logic       x_prev_q;
  logic       x_now;

  ds_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({data_i, strb_i}),
    .q_o   (ds_s)
  );

  assign x_now = ds_s[1] ^ ds_s[0];

  // prev tracks even while disabled, so re-enable adds no bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_prev_q <= 1'b0;
      stb_o    <= 1'b0;
      bit_o    <= 1'b0;
    end else begin
      x_prev_q <= x_now;
      stb_o    <= en_i && (x_now != x_prev_q);
      bit_o    <= ds_s[1];
    end
  end

  assert_stb_enabled_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |-> $past(en_i));
endmodule

// File: rtl/ds_deser.sv
module ds_deser
  import ds_rx_pkg::*;
#(
  parameter int unsigned DW = LANES_HI
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  speed_e        speed_i,
  input  logic          bit_i,
  input  logic          stb_i,
  output logic [DW-1:0] word_o,
  output logic          push_o
);
  localparam int unsigned CW = $clog2(DW);

  logic [DW-2:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_idx;
  logic [DW-1:0] word_lo, word_hi;

  assign last_idx = (speed_i == SPD_HI) ? CW'(LANES_HI - 1) : CW'(LANES_LO - 1);
  assign word_hi  = {sh_q, bit_i};
  assign word_lo  = {{(DW-LANES_LO){1'b0}}, sh_q[LANES_LO-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      push_o <= 1'b0;
      word_o <= '0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      push_o <= 1'b0;
    end else begin
      push_o <= 1'b0;
      if (stb_i) begin
        sh_q <= {sh_q[DW-3:0], bit_i};
        if (cnt_q == last_idx) begin
          cnt_q  <= '0;
          push_o <= 1'b1;
          word_o <= (speed_i == SPD_HI) ? word_hi : word_lo;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assert_push_after_bit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> $past(stb_i));
  assert_no_push_disabled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !push_o);
endmodule

// File: rtl/ds_async_fifo.sv
module ds_async_fifo #(
  parameter int unsigned DW          = 4,
  parameter int unsigned AW          = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic          ovf_o
);
  localparam int unsigned PW    = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin_q, wgray_q, rbin_q, rgray_q;
  logic [PW-1:0] rgray_w, wgray_r;
  logic [PW-1:0] wbin_nx, rbin_nx;
  logic          full, empty, ovf_q;

  ds_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rgray_q), .q_o(rgray_w));
  ds_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wgray_q), .q_o(wgray_r));
  ds_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ovf (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(ovf_q), .q_o(ovf_o));

  assign wbin_nx = wbin_q + 1'b1;
  assign rbin_nx = rbin_q + 1'b1;
  assign full    = (wgray_q == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});
  assign empty   = (rgray_q == wgray_r);

  always_ff @(posedge wclk_i) begin
    if (push_i && !full) mem[wbin_q[AW-1:0]] <= wdata_i;
  end

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      ovf_q   <= 1'b0;
    end else if (push_i) begin
      if (full) begin
        ovf_q <= 1'b1;
      end else begin
        wbin_q  <= wbin_nx;
        wgray_q <= wbin_nx ^ (wbin_nx >> 1);
      end
    end
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q   <= '0;
      rgray_q  <= '0;
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else if (!empty) begin
      rdata_o  <= mem[rbin_q[AW-1:0]];
      rvalid_o <= 1'b1;
      rbin_q   <= rbin_nx;
      rgray_q  <= rbin_nx ^ (rbin_nx >> 1);
    end else begin
      rvalid_o <= 1'b0;
    end
  end

  assert_gray_step_R5: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);
  assert_occupancy_R6: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (g2b(wgray_r) - rbin_q) <= PW'(DEPTH));
  assert_sticky_ovf_R8: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
endmodule

// File: rtl/ds_rx_resync.sv
module ds_rx_resync
  import ds_rx_pkg::*;
#(
  parameter int unsigned DW          = LANES_HI,
  parameter int unsigned FIFO_AW     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_s_i,
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_a_data_i,
  input  logic          rx_b_strb_i,
  input  logic          speed_i,
  input  logic          rx_en_i,
  output logic [DW-1:0] par_data_o,
  output logic          par_valid_o,
  output logic          rep_bit_o,
  output logic          rep_stb_o,
  output logic          ovf_err_o
);
  logic          bit_d, stb_d, push;
  logic [DW-1:0] word;

  ds_edge_decode #(.SYNC_STAGES(SYNC_STAGES)) u_dec (
    .clk_i (clk_s_i),
    .rst_ni(rst_ni),
    .data_i(rx_a_data_i),
    .strb_i(rx_b_strb_i),
    .en_i  (rx_en_i),
    .bit_o (bit_d),
    .stb_o (stb_d)
  );

  assign rep_bit_o = bit_d;
  assign rep_stb_o = stb_d;

  ds_deser #(.DW(DW)) u_deser (
    .clk_i  (clk_s_i),
    .rst_ni (rst_ni),
    .en_i   (rx_en_i),
    .speed_i(speed_e'(speed_i)),
    .bit_i  (bit_d),
    .stb_i  (stb_d),
    .word_o (word),
    .push_o (push)
  );

  ds_async_fifo #(.DW(DW), .AW(FIFO_AW), .SYNC_STAGES(SYNC_STAGES)) u_fifo (
    .wclk_i  (clk_s_i),
    .rclk_i  (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .wdata_i (word),
    .rdata_o (par_data_o),
    .rvalid_o(par_valid_o),
    .ovf_o   (ovf_err_o)
  );
endmodule

// File: tb/ds_rx_resync_tb_top.sv
module ds_rx_resync_tb_top;
  localparam int SYS_PERIOD = 20;
  localparam int SMP_PERIOD = 4;

  logic clk_s = 1'b0, clk = 1'b0, rst_n = 1'b0;
  logic a_d = 1'b0, b_s = 1'b0, spd = 1'b0, en = 1'b0;
  logic [3:0] pdata;
  logic pvalid, rbit, rstb, ovf;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [3:0] got[$];
  logic       rep_got[$];

  always #(SMP_PERIOD/2) clk_s = ~clk_s;
  always #(SYS_PERIOD/2) clk = ~clk;

  ds_rx_resync dut_i (
    .clk_s_i(clk_s), .clk_i(clk), .rst_ni(rst_n),
    .rx_a_data_i(a_d), .rx_b_strb_i(b_s), .speed_i(spd), .rx_en_i(en),
    .par_data_o(pdata), .par_valid_o(pvalid),
    .rep_bit_o(rbit), .rep_stb_o(rstb), .ovf_err_o(ovf)
  );

  always @(negedge clk) if (pvalid) got.push_back(pdata);
  always @(negedge clk_s) if (rstb) rep_got.push_back(rbit);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input int hold);
    @(negedge clk_s);
    if (b != a_d) a_d = b;
    else          b_s = ~b_s;
    repeat (hold - 1) @(negedge clk_s);
  endtask

  task automatic clear_mon();
    repeat (30) @(negedge clk);
    got.delete();
    rep_got.delete();
  endtask

  task automatic run_words(input logic s, input logic [15:0] pat, input string req);
    int lanes = s ? 4 : 2;
    clear_mon();
    spd = s;
    for (int i = 15; i >= 0; i--) send_bit(pat[i], 4);
    repeat (30) @(negedge clk);
    check(got.size() == 16 / lanes, req, got.size(), 16 / lanes);
    check(rep_got.size() == 16, "R2", rep_got.size(), 16);
    for (int i = 0; i < 16 && i < rep_got.size(); i++)
      check(rep_got[i] == pat[15-i], "R1", rep_got[i], pat[15-i]);
    for (int w = 0; w < got.size() && w < 16 / lanes; w++) begin
      logic [3:0] e = '0;
      for (int k = 0; k < lanes; k++) e[lanes-1-k] = pat[15 - w*lanes - k];
      check(got[w] == e, req, got[w], e);
    end
  endtask

  task automatic t_reset();
    check(pvalid == 1'b0, "R9", pvalid, 0);
    check(rstb == 1'b0, "R9", rstb, 0);
    check(ovf == 1'b0, "R9", ovf, 0);
  endtask

  task automatic t_underflow();
    int hi = 0;
    repeat (15) begin
      @(negedge clk);
      if (pvalid) hi++;
    end
    check(hi == 0, "R6", hi, 0);
  endtask

  task automatic t_disable();
    clear_mon();
    spd = 1'b0;
    send_bit(1'b1, 4);
    repeat (6) @(negedge clk_s);
    en = 1'b0;
    send_bit(1'b1, 3); send_bit(1'b0, 3); send_bit(1'b0, 3); send_bit(1'b1, 3);
    repeat (6) @(negedge clk_s);
    check(rep_got.size() == 1, "R7", rep_got.size(), 1);
    en = 1'b1;
    send_bit(1'b0, 4); send_bit(1'b1, 4);
    repeat (30) @(negedge clk);
    check(got.size() == 1, "R7", got.size(), 1);
    if (got.size() > 0) check(got[0] == 4'b0001, "R7", got[0], 4'b0001);
    check(rep_got.size() == 3, "R7", rep_got.size(), 3);
  endtask

  task automatic t_overflow();
    clear_mon();
    spd = 1'b0;
    for (int i = 0; i < 24; i++) send_bit(i[1] ^ i[0], 1);
    repeat (30) @(negedge clk);
    check(ovf == 1'b1, "R8", ovf, 1);
    check(got.size() < 12, "R8", got.size(), 11);
    repeat (20) @(negedge clk);
    check(ovf == 1'b1, "R8", ovf, 1);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(ovf == 1'b0, "R9", ovf, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    en = 1'b1;
    run_words(1'b0, 16'hB4E1, "R3");
    t_underflow();
    run_words(1'b1, 16'h3C95, "R4");
    run_words(1'b1, 16'hF00F, "R5");
    run_words(1'b0, 16'h00FF, "R5");
    t_underflow();
    t_disable();
    t_overflow();
    repeat (5) @(negedge clk);
    t_reset();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule